// File: doc/BRIEF.md
# Inclusive L2 Victim Selector

This block picks the way to replace when an inclusive second-level cache allocates a new line. Several first-level caches sit in front of that cache. For every line in every set, the block keeps a full recency ordering across the ways. It also keeps one holder bit per first-level cache, which records which of those caches currently hold a copy of the line.

Three streams drive the stored state:

- **Fill requests** ask for a victim in a given set.
- **Hit hints** come from a first-level cache that hit on a line. A hint refreshes the line's recency, so lines that are busy in the first-level caches do not age out of the second level.
- **Release notices** say that a first-level cache has dropped a line.

The victim choice works in three tiers:

1. An empty way is taken first.
2. If there is no empty way, the block takes the least recently used way that no first-level cache holds.
3. If every way is held, the least recently used way is evicted anyway. The block then returns a back-invalidate mask that names every first-level cache that must discard its copy.

The answer to a fill arrives one cycle after the request. On that same edge, the filled way becomes most recently used, and it is marked as held only by the cache that asked for it.

Top module: `inclusive_victim_sel`

## Requirements
- R1: `rsp_vld` is high in the cycle after each cycle with `fill_req` high, and low in the cycle after any cycle with `fill_req` low.
- R2: Reset is synchronous and active high. It leaves every way empty and every holder bit clear. It sets each way's age equal to its index: age 0 is most recently used and age WAYS-1 is least recently used. After reset, the first fill to any set returns way 0.
- R3: If a set has at least one empty way, the lowest-numbered empty way is returned. `rsp_evict` is 0 and `rsp_binv` is all zero.
- R4: If no way is empty, the least recently used way with no holder bit set is returned. `rsp_evict` is 1 and `rsp_binv` is all zero.
- R5: If every way has at least one holder bit set, the way with age WAYS-1 is returned. `rsp_evict` is 1, and `rsp_binv` equals that way's holder vector, where bit i stands for first-level cache i.
- R6: A filled way becomes most recently used. Its holder vector becomes a single bit for `fill_src`, and every other bit is cleared.
- R7: A hint moves the named way to most recently used. It also sets the holder bit of `hint_src` for that line.
- R8: A release clears only the holder bit of `rel_src` for the named line. Other caches' bits are left as they are.
- R9: A hint and a release for the same line in the same cycle both take effect. The recency is refreshed. When both come from the same source, the bit ends up cleared.
- R10: A hint to the set that is being filled in the same cycle is dropped. Neither the recency nor the holder bits change.
- R11: A release aimed at the line being filled in the same cycle loses to the fill. The new holder vector is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_req | input | 1 | Request a victim in `fill_set` |
| fill_set | input | SET_W | Set index of the fill |
| fill_src | input | SRC_W | First-level cache that caused the fill |
| hint_vld | input | 1 | Hit hint present |
| hint_set | input | SET_W | Set of the hinted line |
| hint_way | input | WAY_W | Way of the hinted line |
| hint_src | input | SRC_W | First-level cache that hit |
| rel_vld | input | 1 | Release notice present |
| rel_set | input | SET_W | Set of the released line |
| rel_way | input | WAY_W | Way of the released line |
| rel_src | input | SRC_W | First-level cache that dropped the line |
| rsp_vld | output | 1 | Victim answer valid |
| rsp_way | output | WAY_W | Chosen way |
| rsp_evict | output | 1 | The chosen way held a valid line |
| rsp_binv | output | PORTS | Back-invalidate mask, bit i for first-level cache i |

## Verification
The bench targets four kinds of defect:

- **Holder vector after a fill.** A set is driven through a sequence in which every way is held. The forced victim is then chosen so that its back-invalidate mask exposes the holder vector left by an earlier fill. A design that ORs in old holder bits, or that lets a same-cycle release win, returns the wrong mask.
- **Same-cycle collisions.** A hint is sent together with a fill to the same set, and a hint is sent together with a release for the same line. A design that lets the hint slip through promotes the wrong way, and the next victim moves by one.
- **Release on a line with two holders.** A release is applied to a line held by both caches. A design that clears the whole vector drops a cache from the invalidate mask.
- **Random traffic.** Random traffic crowded onto four sets checks that the empty-first and unheld-first ordering holds against a model of the requirements.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

   // How the victim was found: an empty way, an unheld valid way, or a
   // forced eviction of a line that some first-level cache still holds.
   typedef enum logic [1:0] {
      PICK_FREE   = 2'd0,
      PICK_UNHELD = 2'd1,
      PICK_FORCED = 2'd2
   } pick_kind_e;

endpackage

// File: rtl/ivs_promote.sv
// Moves one way of a set to most-recently-used. Ways that were younger than
// it age by one step; the others keep their ages.
module ivs_promote #(
   parameter int WAYS  = 8,
   parameter int AGE_W = 3,
   parameter int WAY_W = 3
) (
   input  logic [WAYS-1:0][AGE_W-1:0] age_in,
   input  logic [WAY_W-1:0]           way,
   output logic [WAYS-1:0][AGE_W-1:0] age_out
);

   logic [AGE_W-1:0] pivot;
   assign pivot = age_in[way];

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      always_comb begin
         if (WAY_W'(g) == way) begin
            age_out[g] = '0;
         end else if (age_in[g] < pivot) begin
            age_out[g] = age_in[g] + AGE_W'(1);
         end else begin
            age_out[g] = age_in[g];
         end
      end
   end

endmodule

// File: rtl/ivs_pick.sv
// Chooses the victim way of one set from its valid bits, ages and holder
// vectors.
module ivs_pick
   import ivs_pkg::*;
#(
   parameter int WAYS  = 8,
   parameter int PORTS = 2,
   parameter int AGE_W = 3,
   parameter int WAY_W = 3
) (
   input  logic [WAYS-1:0]             valid_row,
   input  logic [WAYS-1:0][AGE_W-1:0]  age_row,
   input  logic [WAYS-1:0][PORTS-1:0]  pres_row,
   output logic [WAY_W-1:0]            pick_way,
   output pick_kind_e                  pick_kind,
   output logic [PORTS-1:0]            pick_binv
);

   localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

   logic [WAYS-1:0] held;
   for (genvar g = 0; g < WAYS; g++) begin : g_held
      assign held[g] = |pres_row[g];
   end

   logic             free_found;
   logic [WAY_W-1:0] free_way;
   logic             un_found;
   logic [WAY_W-1:0] un_way;
   logic [AGE_W-1:0] un_age;
   logic [WAY_W-1:0] lru_way;

   // lowest-numbered empty way
   always_comb begin
      free_found = 1'b0;
      free_way   = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid_row[w]) begin
            free_found = 1'b1;
            free_way   = WAY_W'(w);
         end
      end
   end

   // oldest way with no holder
   always_comb begin
      un_found = 1'b0;
      un_way   = '0;
      un_age   = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!held[w] && (!un_found || age_row[w] > un_age)) begin
            un_found = 1'b1;
            un_way   = WAY_W'(w);
            un_age   = age_row[w];
         end
      end
   end

   // oldest way overall
   always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (age_row[w] == OLDEST) begin
            lru_way = WAY_W'(w);
         end
      end
   end

   always_comb begin
      if (free_found) begin
         pick_kind = PICK_FREE;
         pick_way  = free_way;
         pick_binv = '0;
      end else if (un_found) begin
         pick_kind = PICK_UNHELD;
         pick_way  = un_way;
         pick_binv = '0;
      end else begin
         pick_kind = PICK_FORCED;
         pick_way  = lru_way;
         pick_binv = pres_row[lru_way];
      end
   end

endmodule

// File: rtl/inclusive_victim_sel.sv
module inclusive_victim_sel
   import ivs_pkg::*;
#(
   parameter int WAYS  = 8,
   parameter int SETS  = 64,
   parameter int PORTS = 2,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS),
   localparam int AGE_W = WAY_W,
   localparam int SRC_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fill_req,
   input  logic [SET_W-1:0] fill_set,
   input  logic [SRC_W-1:0] fill_src,
   input  logic             hint_vld,
   input  logic [SET_W-1:0] hint_set,
   input  logic [WAY_W-1:0] hint_way,
   input  logic [SRC_W-1:0] hint_src,
   input  logic             rel_vld,
   input  logic [SET_W-1:0] rel_set,
   input  logic [WAY_W-1:0] rel_way,
   input  logic [SRC_W-1:0] rel_src,
   output logic             rsp_vld,
   output logic [WAY_W-1:0] rsp_way,
   output logic             rsp_evict,
   output logic [PORTS-1:0] rsp_binv
);

   // elaboration-time parameter checks
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (PORTS < 1) begin : g_bad_ports
      $error("PORTS must be at least 1");
   end

   // per-set state
   logic [WAYS-1:0]            val_q  [SETS];
   logic [WAYS-1:0][AGE_W-1:0] age_q  [SETS];
   logic [WAYS-1:0][PORTS-1:0] pres_q [SETS];

   // fill path
   logic [WAYS-1:0]            f_val;
   logic [WAYS-1:0][AGE_W-1:0] f_age;
   logic [WAYS-1:0][PORTS-1:0] f_pres;
   logic [WAYS-1:0][AGE_W-1:0] f_age_nx;
   logic [WAY_W-1:0]           pick_way;
   pick_kind_e                 pick_kind;
   logic [PORTS-1:0]           pick_binv;
   logic [PORTS-1:0]           fill_pres;

   assign f_val  = val_q[fill_set];
   assign f_age  = age_q[fill_set];
   assign f_pres = pres_q[fill_set];

   always_comb begin
      for (int p = 0; p < PORTS; p++) begin
         fill_pres[p] = (SRC_W'(p) == fill_src);
      end
   end

   ivs_pick #(
      .WAYS (WAYS),
      .PORTS(PORTS),
      .AGE_W(AGE_W),
      .WAY_W(WAY_W)
   ) u_pick (
      .valid_row(f_val),
      .age_row  (f_age),
      .pres_row (f_pres),
      .pick_way (pick_way),
      .pick_kind(pick_kind),
      .pick_binv(pick_binv)
   );

   ivs_promote #(
      .WAYS (WAYS),
      .AGE_W(AGE_W),
      .WAY_W(WAY_W)
   ) u_fill_promote (
      .age_in (f_age),
      .way    (pick_way),
      .age_out(f_age_nx)
   );

   // hint path
   logic [WAYS-1:0][AGE_W-1:0] h_age;
   logic [WAYS-1:0][AGE_W-1:0] h_age_nx;
   logic                       hint_take;

   assign h_age     = age_q[hint_set];
   assign hint_take = hint_vld && !(fill_req && (fill_set == hint_set));

   ivs_promote #(
      .WAYS (WAYS),
      .AGE_W(AGE_W),
      .WAY_W(WAY_W)
   ) u_hint_promote (
      .age_in (h_age),
      .way    (hint_way),
      .age_out(h_age_nx)
   );

   // state update: hint, then release, then fill; later writes win
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) begin
            val_q[s]  <= '0;
            pres_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               age_q[s][w] <= AGE_W'(w);
            end
         end
         rsp_vld   <= 1'b0;
         rsp_way   <= '0;
         rsp_evict <= 1'b0;
         rsp_binv  <= '0;
      end else begin
         if (hint_take) begin
            age_q[hint_set]                     <= h_age_nx;
            pres_q[hint_set][hint_way][hint_src] <= 1'b1;
         end
         if (rel_vld) begin
            pres_q[rel_set][rel_way][rel_src] <= 1'b0;
         end
         if (fill_req) begin
            age_q[fill_set]            <= f_age_nx;
            val_q[fill_set][pick_way]  <= 1'b1;
            pres_q[fill_set][pick_way] <= fill_pres;
         end
         rsp_vld   <= fill_req;
         rsp_way   <= fill_req ? pick_way : '0;
         rsp_evict <= fill_req && (pick_kind != PICK_FREE);
         rsp_binv  <= fill_req ? pick_binv : '0;
      end
   end

endmodule

// File: rtl/ivs_chk.sv
module ivs_chk #(
   parameter int WAYS  = 8,
   parameter int PORTS = 2,
   parameter int AGE_W = 3
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       fill_req,
   input logic                       rsp_vld,
   input logic                       rsp_evict,
   input logic [PORTS-1:0]           rsp_binv,
   input logic [WAYS-1:0][AGE_W-1:0] fill_age
);

   // every age value appears exactly once in the set being filled
   logic [WAYS-1:0] seen;
   always_comb begin
      seen = '0;
      for (int w = 0; w < WAYS; w++) begin
         seen[fill_age[w]] = 1'b1;
      end
   end

   // R1
   rsp_follows_fill_chk: assert property (@(posedge clk) disable iff (rst)
      fill_req |=> rsp_vld);

   // R1
   no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
      !fill_req |=> !rsp_vld);

   // R3
   empty_pick_no_binv_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_vld && !rsp_evict) |-> (rsp_binv == '0));

   // R5
   binv_only_on_evict_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_binv != '0) |-> (rsp_vld && rsp_evict));

   // R6
   age_order_full_chk: assert property (@(posedge clk) disable iff (rst)
      fill_req |-> (&seen));

endmodule

bind inclusive_victim_sel ivs_chk #(
   .WAYS (WAYS),
   .PORTS(PORTS),
   .AGE_W(AGE_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .fill_req (fill_req),
   .rsp_vld  (rsp_vld),
   .rsp_evict(rsp_evict),
   .rsp_binv (rsp_binv),
   .fill_age (f_age)
);

// File: tb/tb_inclusive_victim_sel.sv
`timescale 1ns/1ps
module tb_inclusive_victim_sel;

   localparam int WAYS  = 8;
   localparam int SETS  = 64;
   localparam int PORTS = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       fill_req = 1'b0;
   logic [5:0] fill_set = '0;
   logic [0:0] fill_src = '0;
   logic       hint_vld = 1'b0;
   logic [5:0] hint_set = '0;
   logic [2:0] hint_way = '0;
   logic [0:0] hint_src = '0;
   logic       rel_vld = 1'b0;
   logic [5:0] rel_set = '0;
   logic [2:0] rel_way = '0;
   logic [0:0] rel_src = '0;
   logic       rsp_vld;
   logic [2:0] rsp_way;
   logic       rsp_evict;
   logic [1:0] rsp_binv;

   always #4 clk = ~clk;

   inclusive_victim_sel #(.WAYS(WAYS), .SETS(SETS), .PORTS(PORTS)) dut (
      .clk(clk), .rst(rst),
      .fill_req(fill_req), .fill_set(fill_set), .fill_src(fill_src),
      .hint_vld(hint_vld), .hint_set(hint_set), .hint_way(hint_way), .hint_src(hint_src),
      .rel_vld(rel_vld), .rel_set(rel_set), .rel_way(rel_way), .rel_src(rel_src),
      .rsp_vld(rsp_vld), .rsp_way(rsp_way), .rsp_evict(rsp_evict), .rsp_binv(rsp_binv)
   );

   int n_chk  = 0;
   int n_fail = 0;

   // model of the requirements
   bit       m_val  [SETS][WAYS];
   int       m_age  [SETS][WAYS];
   bit [1:0] m_pres [SETS][WAYS];

   bit       pend = 0;
   int       e_way;
   bit       e_ev;
   bit [1:0] e_bv;
   string    pend_tag;

   function automatic void m_reset();
      for (int s = 0; s < SETS; s++) begin
         for (int w = 0; w < WAYS; w++) begin
            m_val[s][w]  = 0;
            m_age[s][w]  = w;
            m_pres[s][w] = 2'b00;
         end
      end
   endfunction

   function automatic void m_pick(input int s, output int way, output bit ev, output bit [1:0] bv);
      int best;
      way = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_val[s][w]) way = w;
      if (way >= 0) begin ev = 0; bv = 2'b00; return; end
      best = -1;
      for (int w = 0; w < WAYS; w++)
         if (m_pres[s][w] == 2'b00 && m_age[s][w] > best) begin best = m_age[s][w]; way = w; end
      ev = 1;
      if (way >= 0) begin bv = 2'b00; return; end
      for (int w = 0; w < WAYS; w++) if (m_age[s][w] == WAYS - 1) way = w;
      bv = m_pres[s][way];
   endfunction

   function automatic void m_promote(input int s, input int w);
      int a = m_age[s][w];
      for (int v = 0; v < WAYS; v++) begin
         if (v == w) m_age[s][v] = 0;
         else if (m_age[s][v] < a) m_age[s][v] = m_age[s][v] + 1;
      end
   endfunction

   task automatic chk(input bit ok, input string tag);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: act vld=%0b way=%0d ev=%0b binv=%b exp vld=%0b way=%0d ev=%0b binv=%b",
                  tag, rsp_vld, rsp_way, rsp_evict, rsp_binv, pend, e_way, e_ev, e_bv);
      end
   endtask

   task automatic cyc(input bit f, input int fs, input int fsrc,
                      input bit h, input int hs, input int hw, input int hsrc,
                      input bit r, input int rs, input int rw, input int rsrc,
                      input string tag);
      @(negedge clk);
      if (pend)
         chk(rsp_vld && rsp_way == 3'(e_way) && rsp_evict == e_ev && rsp_binv == e_bv, pend_tag);
      else
         chk(!rsp_vld, "R1");
      fill_req = f; fill_set = 6'(fs); fill_src = 1'(fsrc);
      hint_vld = h; hint_set = 6'(hs); hint_way = 3'(hw); hint_src = 1'(hsrc);
      rel_vld  = r; rel_set  = 6'(rs); rel_way  = 3'(rw); rel_src  = 1'(rsrc);
      pend = f;
      if (f) begin
         m_pick(fs, e_way, e_ev, e_bv);
         if (tag != "") pend_tag = tag;
         else pend_tag = e_ev ? ((e_bv != 2'b00) ? "R5" : "R4") : "R3";
      end
      if (h && !(f && fs == hs)) begin
         m_promote(hs, hw);
         m_pres[hs][hw][hsrc] = 1'b1;
      end
      if (r) m_pres[rs][rw][rsrc] = 1'b0;
      if (f) begin
         m_promote(fs, e_way);
         m_val[fs][e_way]  = 1'b1;
         m_pres[fs][e_way] = 2'b01 << fsrc;
      end
   endtask

   task automatic fill1(input int s, input int src, input string tag);
      cyc(1, s, src, 0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic hint1(input int s, input int w, input int src);
      cyc(0, 0, 0, 1, s, w, src, 0, 0, 0, 0, "");
   endtask
   task automatic rel1(input int s, input int w, input int src);
      cyc(0, 0, 0, 0, 0, 0, 0, 1, s, w, src, "");
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act running exp finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      m_reset();
      // R2: outputs quiet during reset
      repeat (3) begin
         @(negedge clk);
         chk(!rsp_vld && rsp_binv == 2'b00, "R2");
      end
      rst = 1'b0;

      fill1(0, 0, "R2");
      // R3: empty ways taken lowest first
      for (int i = 0; i < WAYS; i++) fill1(5, 0, "R3");
      fill1(5, 1, "R5");
      rel1(5, 3, 0);
      fill1(5, 0, "R4");

      // R6: refilled way is MRU and held only by its requester
      for (int i = 0; i < WAYS; i++) fill1(60, 0, "R3");
      fill1(60, 1, "R5");
      for (int i = 0; i < WAYS - 1; i++) fill1(60, 0, "R5");
      fill1(60, 0, "R6");

      // R11: release on the line being filled loses
      for (int i = 0; i < WAYS; i++) fill1(40, 0, "R3");
      cyc(1, 40, 1, 0, 0, 0, 0, 1, 40, 0, 1, "R5");
      for (int i = 0; i < WAYS - 1; i++) fill1(40, 0, "R5");
      fill1(40, 0, "R11");

      // R8: release clears only one holder of a shared line
      for (int i = 0; i < WAYS; i++) fill1(50, 0, "R3");
      hint1(50, 0, 1);
      for (int i = 1; i < WAYS; i++) hint1(50, i, 0);
      rel1(50, 0, 0);
      fill1(50, 0, "R8");

      // R9, R7, R10 on set 9
      for (int i = 0; i < WAYS; i++) fill1(9, 0, "R3");
      for (int i = 0; i < WAYS; i++) rel1(9, i, 0);
      cyc(0, 0, 0, 1, 9, 0, 0, 1, 9, 0, 0, "");
      fill1(9, 0, "R9");
      hint1(9, 2, 1);
      rel1(9, 2, 1);
      fill1(9, 0, "R7");
      cyc(1, 9, 0, 1, 9, 5, 0, 0, 0, 0, 0, "R4");
      fill1(9, 0, "R10");

      // constrained random traffic on a few crowded sets
      for (int i = 0; i < 3000; i++) begin
         cyc(($urandom % 100) < 50, $urandom % 4, $urandom % 2,
             ($urandom % 100) < 35, $urandom % 4, $urandom % WAYS, $urandom % 2,
             ($urandom % 100) < 45, $urandom % 4, $urandom % WAYS, $urandom % 2, "");
      end
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");

      summary();
      $finish;
   end

endmodule